// File: doc/BRIEF.md
# USB Interrupt Flag Controller

This block gathers single-cycle event strobes from a USB device core into two flag registers: one for endpoint events and one for bus events. Each flag stays set until software writes a 1 to its bit position. A companion enable register masks each flag. The unmasked flags are combined into a single interrupt request. A global enable bit in a control register gates that request before it reaches the interrupt pin.

The pin has two signalling modes. In level mode it acts as an open-drain, active-low line. It pulls low while any enabled flag is pending and is released otherwise. In edge mode it is always driven. It rests at the inactive level and emits a fixed-length pulse each time the set of pending enabled flags gains a member. A control bit selects the polarity of that pulse. Software reaches all registers through a simple single-cycle write strobe and a combinational read port.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After reset, every flag, enable and control bit is 0. The pin is then in edge mode with negative polarity and no global enable, so `int_oe`=1 and `int_o`=1.
- R2: An event strobe sets the flag at the same position, and the flag is readable on the next cycle. The register map is: address 0 endpoint flags (bits 5:0), address 1 endpoint enables, address 2 bus flags (bits 7:0), address 3 bus enables, address 4 control. Bits 7:6 at addresses 0 and 1 always read 0, and writes to them are ignored. Addresses 5 to 7 read 0.
- R3: Writing a 1 to a flag bit clears that bit. Writing a 0 leaves it unchanged.
- R4: If an event strobe and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Enable registers are read/write, with each enable bit at the same position as its flag. A flag whose enable is 0 has no effect on the pin.
- R6: Control bit 0 is the global enable. While it is 0, the pin never signals: in level mode `int_oe`=0, and in edge mode the pin holds its inactive level.
- R7: Control bit 1 = 1 selects level mode. The pin then drives low (`int_oe`=1, `int_o`=0) while the global enable is 1 and any enabled flag is set. Otherwise `int_oe`=0.
- R8: Control bit 1 = 0 selects edge mode, with `int_oe`=1 at all times. Control bit 2 is the active level: 1 gives pulses high over a low rest level, and 0 gives pulses low over a high rest level.
- R9: In edge mode, a pending enabled flag that newly appears (or becomes visible when an enable is set) makes the pin active on the cycle after the flag becomes readable. The pin stays active for PULSE_LEN cycles.
- R10: If one or more new pending flags appear while a pulse is active, exactly one more pulse follows, after one inactive cycle.
- R11: A flag that stays pending, a repeated event on an already-set flag, or a flag being cleared starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_evt | input | 6 | Endpoint event strobes, one cycle each |
| bus_evt | input | 8 | Bus event strobes, one cycle each |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| int_o | output | 1 | Interrupt pin level |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that event strobes and write strobes are either 0 or 1 at each clock edge, with no X values. The bench meets these assumptions by holding reset and all inputs at 0 during the first cycles. After that it changes inputs only shortly after a rising edge, so every strobe is settled before the next edge. The pulse checks also assume that the control register is not rewritten while a pulse is running, and the stimulus changes modes only when the pin is at rest.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int EP_W   = 6;
    localparam int BUS_W  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int PEND_W = EP_W + BUS_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_EP_FLAG  = 3'd0,
        SEL_EP_EN    = 3'd1,
        SEL_BUS_FLAG = 3'd2,
        SEL_BUS_EN   = 3'd3,
        SEL_CTRL     = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic pos_pol;
        logic level_mode;
        logic gie;
    } int_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } pulse_st_e;

    function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v, input int w);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
        return v & m;
    endfunction
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         wr_flag,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags,
    output logic [W-1:0] enables
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[b]   <= 1'b0;
                enables[b] <= 1'b0;
            end else begin
                // a strobe in the same cycle as a clear keeps the bit set
                flags[b] <= evt[b] | (flags[b] & ~(wr_flag & wdata[b]));
                if (wr_en) enables[b] <= wdata[b];
            end
        end
    end
endmodule

// File: rtl/int_edge_gen.sv
module int_edge_gen
    import usb_irq_pkg::*;
#(
    parameter int N         = 14,
    parameter int PULSE_LEN = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    output logic         pulse
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    pulse_st_e      st;
    logic [CNT_W-1:0] cnt;
    logic           owed;
    logic [N-1:0]   pend_q;
    logic           grow;

    assign grow = |(pend & ~pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            owed   <= 1'b0;
            pend_q <= '0;
        end else begin
            pend_q <= pend;
            case (st)
                ST_IDLE: begin
                    if (grow) begin
                        st  <= ST_PULSE;
                        cnt <= '0;
                    end
                end
                ST_PULSE: begin
                    if (grow) owed <= 1'b1;
                    if (cnt == CNT_W'(PULSE_LEN - 1)) st <= ST_GAP;
                    else cnt <= cnt + 1'b1;
                end
                ST_GAP: begin
                    if (owed || grow) begin
                        st  <= ST_PULSE;
                        cnt <= '0;
                    end else begin
                        st <= ST_IDLE;
                    end
                    owed <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign pulse = (st == ST_PULSE);
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EP_W-1:0]   ep_evt,
    input  logic [BUS_W-1:0]  bus_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              int_o,
    output logic              int_oe
);
    logic [EP_W-1:0]  ep_flags, ep_en;
    logic [BUS_W-1:0] bus_flags, bus_en;
    int_cfg_t         cfg;
    logic [PEND_W-1:0] pend;
    logic             pulse;
    logic             level_mode_w, gie_w;

    logic wr_ep_f, wr_ep_e, wr_bus_f, wr_bus_e, wr_ctl;
    assign wr_ep_f  = reg_wr && (reg_addr == SEL_EP_FLAG);
    assign wr_ep_e  = reg_wr && (reg_addr == SEL_EP_EN);
    assign wr_bus_f = reg_wr && (reg_addr == SEL_BUS_FLAG);
    assign wr_bus_e = reg_wr && (reg_addr == SEL_BUS_EN);
    assign wr_ctl   = reg_wr && (reg_addr == SEL_CTRL);

    irq_flag_reg #(.W(EP_W)) u_ep (
        .clk(clk), .rst(rst), .evt(ep_evt),
        .wr_flag(wr_ep_f), .wr_en(wr_ep_e), .wdata(reg_wdata[EP_W-1:0]),
        .flags(ep_flags), .enables(ep_en)
    );

    irq_flag_reg #(.W(BUS_W)) u_bus (
        .clk(clk), .rst(rst), .evt(bus_evt),
        .wr_flag(wr_bus_f), .wr_en(wr_bus_e), .wdata(reg_wdata[BUS_W-1:0]),
        .flags(bus_flags), .enables(bus_en)
    );

    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else if (wr_ctl) cfg <= reg_wdata[2:0];
    end

    assign level_mode_w = cfg.level_mode;
    assign gie_w        = cfg.gie;

    assign pend = cfg.gie ? {bus_flags & bus_en, ep_flags & ep_en} : '0;

    int_edge_gen #(.N(PEND_W), .PULSE_LEN(PULSE_LEN)) u_edge (
        .clk(clk), .rst(rst), .pend(pend), .pulse(pulse)
    );

    always_comb begin
        if (cfg.level_mode) begin
            int_oe = |pend;
            int_o  = 1'b0;
        end else begin
            int_oe = 1'b1;
            int_o  = pulse ? cfg.pos_pol : ~cfg.pos_pol;
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_EP_FLAG:  reg_rdata = widen(DATA_W'(ep_flags), EP_W);
            SEL_EP_EN:    reg_rdata = widen(DATA_W'(ep_en), EP_W);
            SEL_BUS_FLAG: reg_rdata = widen(DATA_W'(bus_flags), BUS_W);
            SEL_BUS_EN:   reg_rdata = widen(DATA_W'(bus_en), BUS_W);
            SEL_CTRL:     reg_rdata = DATA_W'(cfg);
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
    import usb_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [EP_W-1:0]   ep_evt,
    input logic [EP_W-1:0]   ep_flags,
    input logic              level_mode,
    input logic              gie,
    input logic              int_o,
    input logic              int_oe
);
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|ep_evt) |=> ((ep_flags & $past(ep_evt)) == $past(ep_evt))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == SEL_EP_FLAG) |=>
        ((ep_flags & $past(reg_wdata[EP_W-1:0]) & ~$past(ep_evt)) == '0)); // R3

    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == SEL_EP_FLAG) |=>
        ((ep_flags & $past(ep_flags)) == $past(ep_flags))); // R3

    AST_LEVEL_ACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
        (level_mode && int_oe) |-> !int_o); // R7

    AST_GATE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (level_mode && !gie) |-> !int_oe); // R6

    AST_EDGE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !level_mode |-> int_oe); // R8

    AST_EP_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SEL_EP_FLAG) |-> (reg_rdata[7:6] == 2'b00)); // R2
endmodule

bind usb_irq_ctrl usb_irq_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_evt(ep_evt),
    .ep_flags(ep_flags), .level_mode(level_mode_w), .gie(gie_w),
    .int_o(int_o), .int_oe(int_oe)
);

// File: tb/test_usb_irq_ctrl.sv
module test_usb_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PLEN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ep_evt = '0;
    logic [7:0] bus_evt = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_o, int_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    usb_irq_ctrl #(.PULSE_LEN(PLEN)) i_usb_irq_ctrl (
        .clk(clk), .rst(rst), .ep_evt(ep_evt), .bus_evt(bus_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_o(int_o), .int_oe(int_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_epf, m_epe, m_busf, m_buse, m_ctl;
    int m_prev, m_left, m_owed;
    bit m_gap;

    function automatic int m_pend();
        if ((m_ctl & 1) == 0) return 0;
        return ((m_busf & m_buse) << 6) | (m_epf & m_epe);
    endfunction

    function automatic int m_read(input int a);
        case (a)
            0: return m_epf;
            1: return m_epe;
            2: return m_busf;
            3: return m_buse;
            4: return m_ctl;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_epf = 0; m_epe = 0; m_busf = 0; m_buse = 0; m_ctl = 0;
            m_prev = 0; m_left = 0; m_owed = 0; m_gap = 0;
        end else begin
            int p;
            bit trig;
            p = m_pend();
            trig = (p & ~m_prev) != 0;
            if (m_left > 0) begin
                if (trig) m_owed = 1;
                m_left = m_left - 1;
                if (m_left == 0) m_gap = 1;
            end else if (m_gap) begin
                m_gap = 0;
                if (m_owed != 0 || trig) m_left = PLEN;
                m_owed = 0;
            end else if (trig) begin
                m_left = PLEN;
            end
            m_prev = p;
            if (reg_wr) begin
                case (reg_addr)
                    0: m_epf  = m_epf & ~(reg_wdata & 8'h3F);
                    1: m_epe  = reg_wdata & 8'h3F;
                    2: m_busf = m_busf & ~int'(reg_wdata);
                    3: m_buse = reg_wdata;
                    4: m_ctl  = reg_wdata & 8'h07;
                    default: ;
                endcase
            end
            m_epf  = m_epf | ep_evt;
            m_busf = m_busf | bus_evt;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // pulse monitor and per-cycle comparison at the falling edge
    int starts = 0, cur_w = 0, last_w = 0;
    bit act_q = 0;
    always @(negedge clk) begin
        if (!rst) begin
            bit lvl, pos, eoe, eo, act;
            lvl = (m_ctl & 2) != 0;
            pos = (m_ctl & 4) != 0;
            if (lvl) begin
                eoe = (m_pend() != 0); eo = 1'b0;
                chk(int_oe == eoe && int_o == eo, "R7 level pin", {int_oe, int_o}, {eoe, eo});
            end else begin
                eoe = 1'b1; eo = (m_left > 0) ? pos : !pos;
                chk(int_oe == eoe && int_o == eo, "R8 edge pin", {int_oe, int_o}, {eoe, eo});
            end
            chk(reg_rdata == 8'(m_read(reg_addr)), "R2 read", reg_rdata, m_read(reg_addr));
            act = !lvl && int_oe && (int_o == pos);
            if (act && !act_q) begin starts++; cur_w = 0; end
            if (act) cur_w++;
            if (!act && act_q) last_w = cur_w;
            act_q = act;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic evt(input int e, input int b);
        @(posedge clk); #2;
        ep_evt = 6'(e); bus_evt = 8'(b);
        @(posedge clk); #2;
        ep_evt = '0; bus_evt = '0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(posedge clk); #2;
        reg_addr = 3'(a);
        #3;
        chk(reg_rdata == 8'(exp), req, reg_rdata, exp);
    endtask

    initial begin
        int s0;
        tick(3);
        rst = 1'b0;
        #3;
        chk(int_oe == 1'b1 && int_o == 1'b1, "R1 pin", {int_oe, int_o}, 2'b11);
        for (int a = 0; a < 5; a++) rd(a, 0, "R1 reg");

        // R2 set and unused bits
        evt(6'h3F, 8'hA5);
        rd(0, 8'h3F, "R2 ep flags");
        rd(2, 8'hA5, "R2 bus flags");
        wr(0, 8'hC0);
        rd(0, 8'h3F, "R2 upper bits ignored");
        wr(6, 8'hFF);
        rd(6, 0, "R2 unused addr");

        // R3 write-one-to-clear
        wr(2, 8'h05);
        rd(2, 8'hA0, "R3 partial clear");
        wr(0, 8'h00);
        rd(0, 8'h3F, "R3 zero no effect");
        wr(0, 8'h3F);
        wr(2, 8'hFF);
        rd(0, 0, "R3 clear ep");
        rd(2, 0, "R3 clear bus");

        // R4 event beats clear
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01; ep_evt = 6'h01;
        @(posedge clk); #2;
        reg_wr = 1'b0; ep_evt = '0;
        rd(0, 8'h01, "R4 event wins");
        wr(0, 8'h01);

        // R5 enables and masking
        wr(1, 8'hEA);
        rd(1, 8'h2A, "R5 ep enables");
        wr(3, 8'h5C);
        rd(3, 8'h5C, "R5 bus enables");
        wr(1, 0); wr(3, 0);
        wr(4, 8'h03);
        evt(6'h01, 0);
        tick(1);
        chk(int_oe == 1'b0, "R5 masked flag", int_oe, 0);
        wr(1, 8'h01);
        tick(1);
        chk(int_oe == 1'b1 && int_o == 1'b0, "R7 asserted", {int_oe, int_o}, 2'b10);
        wr(0, 8'h01);
        tick(1);
        chk(int_oe == 1'b0, "R7 released", int_oe, 0);

        // R6 global gate
        wr(4, 8'h02);
        evt(6'h01, 0);
        tick(2);
        chk(int_oe == 1'b0, "R6 level gated", int_oe, 0);
        wr(0, 8'h01);
        wr(4, 8'h04);
        s0 = starts;
        evt(6'h01, 0);
        tick(10);
        chk(starts == s0 && int_o == 1'b0, "R6 edge gated", starts - s0, 0);
        wr(0, 8'h01);

        // R8/R9 single pulse, positive polarity
        wr(1, 8'h3F);
        wr(4, 8'h05);
        tick(3);
        chk(int_o == 1'b0, "R8 rest low", int_o, 0);
        s0 = starts;
        evt(6'h02, 0);
        tick(12);
        chk(starts - s0 == 1, "R9 one pulse", starts - s0, 1);
        chk(last_w == PLEN, "R9 width", last_w, PLEN);

        // R11 no pulse on repeat or clear
        s0 = starts;
        evt(6'h02, 0);
        tick(8);
        wr(0, 8'h02);
        tick(8);
        chk(starts == s0, "R11 no new pulse", starts - s0, 0);

        // R8 negative polarity rest
        wr(4, 8'h01);
        tick(2);
        chk(int_o == 1'b1, "R8 rest high", int_o, 1);
        s0 = starts;
        evt(0, 8'h10);
        wr(3, 8'h10);
        tick(12);
        chk(starts - s0 == 1, "R9 enable-late pulse", starts - s0, 1);
        wr(2, 8'hFF);

        // R10 pulses during an active pulse
        wr(4, 8'h05);
        tick(2);
        s0 = starts;
        evt(6'h04, 0);
        evt(6'h08, 0);
        evt(6'h10, 0);
        tick(20);
        chk(starts - s0 == 2, "R10 one extra pulse", starts - s0, 2);
        chk(last_w == PLEN, "R10 second width", last_w, PLEN);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule